// File: doc/BRIEF.md
# Hex Record Command Receiver

This block sits behind a UART receiver and turns a stream of ASCII characters into decoded command records. A record opens with a colon. After the colon come a length byte, a 16-bit load offset, a type byte, the data bytes and a checksum byte. Each byte travels as two hexadecimal characters. Every character received is copied back to the host through a UART transmitter. The block checks that the record sums to zero, then presents the type, offset, length and data buffer with a one-cycle strobe.

When a record fails its checksum, or claims more data than one 128-byte page, the block sends the error reply itself. A downstream command executor reports the outcome of a good record by pulsing `done_i` or `deny_i`, and the block answers the host with the matching reply. Echo characters and reply characters share one transmit queue with a ready/valid handshake, so they never collide.

Top module: `hex_rec_rx`

## Requirements
- R1: While no record is open, any character other than ':' (0x3A) is echoed and otherwise ignored: it produces no record strobe and no reply.
- R2: After the colon, the fields arrive in this order: length (1 byte), offset (2 bytes, high byte first), type (1 byte), data (length bytes), checksum (1 byte). Each byte is two hex characters, high nibble first. When a record is good, `rec_valid_o` pulses for exactly one cycle. The pulse comes in the cycle after the clock edge that takes the last checksum character, and `rec_type_o`, `rec_offset_o` and `rec_len_o` hold the decoded fields at that time.
- R3: Hex digits 0-9, A-F and a-f are all accepted.
- R4: The 8-bit sum of all decoded bytes, from length through checksum, must be zero. When it is not, there is no strobe and the reply 'X', CR, LF (0x58, 0x0D, 0x0A) is queued after the echo of the last character.
- R5: Every received character, including ':', is queued for transmit in arrival order, as long as the queue has room.
- R6: Inside a record, any character that is not a hex digit (':' included) abandons the record without a strobe and without a reply, and the block goes back to waiting for ':'.
- R7: A record whose length exceeds 128 is read through to its checksum and then rejected with the 'X', CR, LF reply and no strobe, even if its sum is zero.
- R8: Lengths from 0 to 128 are accepted. Data byte i can be read on `rd_data_o` by placing i on `rd_addr_i`.
- R9: A pulse on `done_i` queues '.', CR, LF (0x2E, 0x0D, 0x0A). A pulse on `deny_i` queues 'P', CR, LF (0x50, 0x0D, 0x0A). A request that arrives while a reply is still being queued is dropped. When requests arrive in the same cycle, the checksum error wins over deny, and deny wins over done.
- R10: `tx_data_o` stays steady while `tx_valid_o` is high and `tx_ready_i` is low. If a received character and a reply character both want the queue in the same cycle, the received character goes in first.
- R11: After reset, `tx_valid_o` and `rec_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe for a received character |
| rx_data_i | input | 8 | Received character |
| tx_valid_o | output | 1 | A transmit character is available |
| tx_data_o | output | 8 | Transmit character |
| tx_ready_i | input | 1 | The transmitter takes the character |
| rec_valid_o | output | 1 | Strobe for a good record |
| rec_type_o | output | 8 | Record type |
| rec_offset_o | output | 16 | Load offset |
| rec_len_o | output | 8 | Data length |
| rd_addr_i | input | 7 | Index into the data buffer |
| rd_data_o | output | 8 | Data byte at that index |
| done_i | input | 1 | Command succeeded, send the success reply |
| deny_i | input | 1 | Command refused, send the security reply |

## Verification
The collision that matters is an echo and a reply both wanting the transmit queue in the same cycle. The bench creates it by pulsing `done_i` on the same edge as a received character. It then checks that the echoed character leaves before '.', CR, LF and that no character is lost. A related overlap is the final checksum character: its echo and the 'X' reply it triggers must come out in that order. A stalled transmitter is also tested, with `tx_ready_i` held low while characters pile up in the queue. The bench checks that nothing goes out during the stall and that the order is intact once the stall ends.

// File: rtl/hex_rec_pkg.sv
package hex_rec_pkg;
  typedef enum logic [1:0] {RPL_NONE, RPL_OK, RPL_DENY, RPL_CSUM} reply_e;
  typedef enum logic [2:0] {ST_HUNT, ST_LEN, ST_OFFH, ST_OFFL, ST_TYPE, ST_DATA, ST_CSUM} pst_e;

  localparam logic [7:0] CH_MARK = 8'h3A;
  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_LF   = 8'h0A;

  // {is_hex, nibble}
  function automatic logic [4:0] hex_decode(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39) return {1'b1, 4'(c - 8'h30)};
    if (c >= 8'h41 && c <= 8'h46) return {1'b1, 4'(c - 8'h37)};
    if (c >= 8'h61 && c <= 8'h66) return {1'b1, 4'(c - 8'h57)};
    return 5'h00;
  endfunction

  function automatic logic [7:0] reply_letter(input reply_e r);
    case (r)
      RPL_OK:   return 8'h2E;
      RPL_DENY: return 8'h50;
      default:  return 8'h58;
    endcase
  endfunction
endpackage

// File: rtl/hex_rec_parser.sv
module hex_rec_parser import hex_rec_pkg::*; #(
  parameter int MAX_LEN = 128,
  localparam int AW = $clog2(MAX_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rec_valid_o,
  output logic          rec_err_o,
  output logic [7:0]    rec_type_o,
  output logic [15:0]   rec_offset_o,
  output logic [7:0]    rec_len_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam logic [7:0] MAX_B = 8'(MAX_LEN);

  pst_e        st_q;
  logic        lo_q;
  logic [3:0]  hi_q;
  logic [7:0]  sum_q, len_q, type_q, cnt_q;
  logic [15:0] off_q;
  logic [7:0]  mem_q [MAX_LEN];

  logic       dig_ok, wr_en;
  logic [3:0] dig;
  logic [7:0] byte_v, sum_n;

  always_comb begin
    {dig_ok, dig} = hex_decode(rx_data_i);
    byte_v = {hi_q, dig};
    sum_n  = sum_q + byte_v;
    wr_en  = rx_valid_i && st_q == ST_DATA && dig_ok && lo_q && cnt_q < MAX_B;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_HUNT; lo_q <= 1'b0; hi_q <= '0; sum_q <= '0;
      len_q <= '0; type_q <= '0; cnt_q <= '0; off_q <= '0;
      rec_valid_o <= 1'b0; rec_err_o <= 1'b0;
    end else begin
      rec_valid_o <= 1'b0;
      rec_err_o   <= 1'b0;
      if (rx_valid_i) begin
        if (st_q == ST_HUNT) begin
          if (rx_data_i == CH_MARK) begin
            st_q <= ST_LEN; lo_q <= 1'b0; sum_q <= '0;
          end
        end else if (!dig_ok) begin
          st_q <= ST_HUNT;
        end else if (!lo_q) begin
          hi_q <= dig;
          lo_q <= 1'b1;
        end else begin
          lo_q  <= 1'b0;
          sum_q <= sum_n;
          case (st_q)
            ST_LEN:  begin len_q <= byte_v; st_q <= ST_OFFH; end
            ST_OFFH: begin off_q[15:8] <= byte_v; st_q <= ST_OFFL; end
            ST_OFFL: begin off_q[7:0] <= byte_v; st_q <= ST_TYPE; end
            ST_TYPE: begin
              type_q <= byte_v;
              cnt_q  <= '0;
              st_q   <= (len_q == 8'd0) ? ST_CSUM : ST_DATA;
            end
            ST_DATA: begin
              cnt_q <= cnt_q + 8'd1;
              if (cnt_q + 8'd1 == len_q) st_q <= ST_CSUM;
            end
            ST_CSUM: begin
              st_q <= ST_HUNT;
              if (sum_n == 8'd0 && len_q <= MAX_B) rec_valid_o <= 1'b1;
              else                                 rec_err_o   <= 1'b1;
            end
            default: st_q <= ST_HUNT;
          endcase
        end
      end
    end
  end

  // page buffer, no reset needed
  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[cnt_q[AW-1:0]] <= byte_v;
  end

  assign rd_data_o    = mem_q[rd_addr_i];
  assign rec_type_o   = type_q;
  assign rec_offset_o = off_q;
  assign rec_len_o    = len_q;
endmodule

// File: rtl/hex_reply_seq.sv
module hex_reply_seq import hex_rec_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       err_i,
  input  logic       deny_i,
  input  logic       done_i,
  input  logic       grant_i,
  output logic       push_o,
  output logic [7:0] char_o,
  output logic       busy_o
);
  reply_e     code_q;
  logic [1:0] idx_q;

  assign busy_o = code_q != RPL_NONE;
  assign push_o = busy_o && grant_i;

  always_comb begin
    case (idx_q)
      2'd0:    char_o = reply_letter(code_q);
      2'd1:    char_o = CH_CR;
      default: char_o = CH_LF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= RPL_NONE;
      idx_q  <= '0;
    end else if (!busy_o) begin
      idx_q <= '0;
      if (err_i)       code_q <= RPL_CSUM;
      else if (deny_i) code_q <= RPL_DENY;
      else if (done_i) code_q <= RPL_OK;
    end else if (grant_i) begin
      idx_q <= idx_q + 2'd1;
      if (idx_q == 2'd2) code_q <= RPL_NONE;
    end
  end
endmodule

// File: rtl/hex_tx_queue.sv
module hex_tx_queue #(
  parameter int DEPTH = 8,
  parameter int W = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         ready_i
);
  logic [W-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = cnt_q == (PW+1)'(DEPTH);
  assign valid_o = cnt_q != '0;
  assign data_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = valid_o && ready_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(do_push) - (PW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/hex_rec_rx.sv
module hex_rec_rx #(
  parameter int MAX_LEN   = 128,
  parameter int TXQ_DEPTH = 8,
  localparam int AW = $clog2(MAX_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  output logic          rec_valid_o,
  output logic [7:0]    rec_type_o,
  output logic [15:0]   rec_offset_o,
  output logic [7:0]    rec_len_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          done_i,
  input  logic          deny_i
);
  logic       rec_err, q_full, rpl_busy, rpl_push, rpl_grant;
  logic [7:0] rpl_char;

  hex_rec_parser #(.MAX_LEN(MAX_LEN)) u_parser (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i,
    .rec_valid_o, .rec_err_o(rec_err),
    .rec_type_o, .rec_offset_o, .rec_len_o,
    .rd_addr_i, .rd_data_o
  );

  // echo owns the queue slot in any cycle a character arrives
  assign rpl_grant = !rx_valid_i && !q_full;

  hex_reply_seq u_reply (
    .clk_i, .rst_ni, .err_i(rec_err), .deny_i, .done_i,
    .grant_i(rpl_grant), .push_o(rpl_push), .char_o(rpl_char), .busy_o(rpl_busy)
  );

  hex_tx_queue #(.DEPTH(TXQ_DEPTH), .W(8)) u_txq (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i || rpl_push),
    .data_i(rx_valid_i ? rx_data_i : rpl_char),
    .full_o(q_full),
    .valid_o(tx_valid_o), .data_o(tx_data_o), .ready_i(tx_ready_i)
  );
endmodule

// File: rtl/hex_rec_rx_chk.sv
module hex_rec_rx_chk #(
  parameter int MAX_LEN = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       rec_valid_o,
  input logic [7:0] rec_len_o,
  input logic       rec_err,
  input logic       q_full,
  input logic       rpl_busy
);
  a_r10_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r5_echo_queued: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !q_full |=> tx_valid_o);

  a_r2_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);

  a_r8_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> rec_len_o <= 8'(MAX_LEN));

  a_r4_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err |-> !rec_valid_o);

  a_r4_err_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err |=> rpl_busy);
endmodule

bind hex_rec_rx hex_rec_rx_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk_i, .rst_ni, .rx_valid_i, .tx_valid_o, .tx_ready_i, .tx_data_o,
  .rec_valid_o, .rec_len_o, .rec_err(rec_err), .q_full(q_full), .rpl_busy(rpl_busy)
);

// File: tb/tb_hex_rec_rx.sv
module tb_hex_rec_rx;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b1, done = 1'b0, deny = 1'b0;
  logic [7:0] rx_data = '0;
  logic [6:0] rd_addr = '0;
  logic tx_valid, rec_valid;
  logic [7:0] tx_data, rec_type, rec_len, rd_data;
  logic [15:0] rec_offset;

  int checks = 0, errors = 0;
  logic [7:0] tx_log [4096];
  int tx_n = 0, rv_n = 0;
  logic [7:0] cap_type, cap_len;
  logic [15:0] cap_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  hex_rec_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rec_valid_o(rec_valid), .rec_type_o(rec_type), .rec_offset_o(rec_offset),
    .rec_len_o(rec_len), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .done_i(done), .deny_i(deny)
  );

  always @(negedge clk) begin
    if (tx_valid && tx_ready && tx_n < 4096) begin tx_log[tx_n] = tx_data; tx_n++; end
    if (rec_valid) begin
      rv_n++; cap_type = rec_type; cap_len = rec_len; cap_off = rec_offset;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_log(input int base, input string s, input string req);
    int bad = -1;
    chk(tx_n == base + s.len(), req, "tx char count", tx_n - base, s.len());
    for (int i = 0; i < s.len() && base + i < tx_n; i++)
      if (bad < 0 && tx_log[base+i] != s[i]) bad = i;
    if (bad >= 0) chk(1'b0, req, $sformatf("tx char %0d", bad), tx_log[base+bad], s[bad]);
  endtask

  task automatic send_char(input byte c);
    @(negedge clk); rx_valid = 1'b1; rx_data = c;
    @(negedge clk); rx_valid = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
    repeat (10) @(negedge clk);
  endtask

  function automatic string rec_str(input logic [7:0] len, input logic [15:0] off,
      input logic [7:0] typ, input logic [7:0] d[$], input bit lc, input bit bad);
    logic [7:0] s;
    string r;
    s = len + off[15:8] + off[7:0] + typ;
    r = lc ? $sformatf(":%02x%04x%02x", len, off, typ) : $sformatf(":%02X%04X%02X", len, off, typ);
    foreach (d[i]) begin
      s += d[i];
      r = {r, lc ? $sformatf("%02x", d[i]) : $sformatf("%02X", d[i])};
    end
    s = 8'(-s) + 8'(bad);
    return {r, lc ? $sformatf("%02x", s) : $sformatf("%02X", s)};
  endfunction

  task automatic t_reset;
    chk(tx_valid == 1'b0, "R11", "tx_valid after reset", tx_valid, 0);
    chk(rec_valid == 1'b0, "R11", "rec_valid after reset", rec_valid, 0);
  endtask

  task automatic t_basic;
    int base = tx_n, rv0 = rv_n;
    string s = rec_str(8'h01, 16'h0010, 8'h00, '{8'h55}, 1'b0, 1'b0);
    send_str(s);
    expect_log(base, s, "R5");
    chk(rv_n == rv0 + 1, "R2", "strobe count", rv_n - rv0, 1);
    chk(cap_type == 8'h00 && cap_len == 8'h01, "R2", "type/len", {cap_type, cap_len}, 16'h0001);
    chk(cap_off == 16'h0010, "R2", "offset", cap_off, 16'h0010);
    rd_addr = 7'd0; #1;
    chk(rd_data == 8'h55, "R8", "data[0]", rd_data, 8'h55);
  endtask

  task automatic t_garbage;
    int base = tx_n, rv0 = rv_n;
    string s = {"zz7", rec_str(8'h02, 16'h1234, 8'h03, '{8'hA5, 8'h5A}, 1'b0, 1'b0)};
    send_str(s);
    expect_log(base, s, "R1");
    chk(rv_n == rv0 + 1, "R1", "strobe count", rv_n - rv0, 1);
    chk(cap_off == 16'h1234, "R2", "offset high byte first", cap_off, 16'h1234);
    rd_addr = 7'd1; #1;
    chk(rd_data == 8'h5A, "R2", "data[1]", rd_data, 8'h5A);
  endtask

  task automatic t_lower;
    int rv0 = rv_n;
    send_str(rec_str(8'h02, 16'habcd, 8'hef, '{8'hBC, 8'hDE}, 1'b1, 1'b0));
    chk(rv_n == rv0 + 1, "R3", "lower-case strobe", rv_n - rv0, 1);
    chk(cap_off == 16'hABCD && cap_type == 8'hEF, "R3", "lower-case fields", cap_off, 16'hABCD);
    rd_addr = 7'd1; #1;
    chk(rd_data == 8'hDE, "R3", "lower-case data", rd_data, 8'hDE);
  endtask

  task automatic t_badcs;
    int base = tx_n, rv0 = rv_n;
    string s = rec_str(8'h01, 16'h0000, 8'h00, '{8'h11}, 1'b0, 1'b1);
    send_str(s);
    expect_log(base, {s, "X\r\n"}, "R4");
    chk(rv_n == rv0, "R4", "no strobe on bad sum", rv_n - rv0, 0);
  endtask

  task automatic t_abort;
    int base = tx_n, rv0 = rv_n;
    send_str(":01G0");
    expect_log(base, ":01G0", "R6");
    chk(rv_n == rv0, "R6", "no strobe after abort", rv_n - rv0, 0);
    send_str(rec_str(8'h00, 16'h0000, 8'h01, '{}, 1'b0, 1'b0));
    chk(rv_n == rv0 + 1, "R6", "hunting resumed", rv_n - rv0, 1);
  endtask

  task automatic t_zero;
    int rv0 = rv_n;
    send_str(":00000001FF");
    chk(rv_n == rv0 + 1 && cap_len == 8'd0 && cap_type == 8'h01, "R8", "zero length", cap_len, 0);
  endtask

  task automatic t_long;
    int base = tx_n, rv0 = rv_n;
    logic [7:0] d[$];
    string s;
    for (int i = 0; i < 129; i++) d.push_back(8'h00);
    s = rec_str(8'h81, 16'h0000, 8'h00, d, 1'b0, 1'b0);
    send_str(s);
    expect_log(base, {s, "X\r\n"}, "R7");
    chk(rv_n == rv0, "R7", "no strobe over 128", rv_n - rv0, 0);
  endtask

  task automatic t_max;
    int rv0 = rv_n;
    logic [7:0] d[$];
    for (int i = 0; i < 128; i++) d.push_back(8'(i) ^ 8'h5A);
    send_str(rec_str(8'h80, 16'h0100, 8'h00, d, 1'b0, 1'b0));
    chk(rv_n == rv0 + 1 && cap_len == 8'h80, "R8", "full page strobe", cap_len, 8'h80);
    rd_addr = 7'd0; #1;
    chk(rd_data == 8'h5A, "R8", "page data[0]", rd_data, 8'h5A);
    rd_addr = 7'd127; #1;
    chk(rd_data == (8'd127 ^ 8'h5A), "R8", "page data[127]", rd_data, 8'd127 ^ 8'h5A);
  endtask

  task automatic pulse(input bit is_done);
    @(negedge clk); if (is_done) done = 1'b1; else deny = 1'b1;
    @(negedge clk); done = 1'b0; deny = 1'b0;
  endtask

  task automatic t_replies;
    int base = tx_n;
    pulse(1'b1); repeat (10) @(negedge clk);
    expect_log(base, ".\r\n", "R9");
    base = tx_n;
    pulse(1'b0); repeat (10) @(negedge clk);
    expect_log(base, "P\r\n", "R9");
    base = tx_n;
    pulse(1'b1); pulse(1'b0); repeat (10) @(negedge clk);
    expect_log(base, ".\r\n", "R9");
    base = tx_n;
    @(negedge clk); done = 1'b1; deny = 1'b1;
    @(negedge clk); done = 1'b0; deny = 1'b0;
    repeat (10) @(negedge clk);
    expect_log(base, "P\r\n", "R9");
  endtask

  task automatic t_collide;
    int base = tx_n, n0;
    @(negedge clk); rx_valid = 1'b1; rx_data = "Q"; done = 1'b1;
    @(negedge clk); rx_valid = 1'b0; done = 1'b0;
    repeat (10) @(negedge clk);
    expect_log(base, "Q.\r\n", "R10");
    tx_ready = 1'b0;
    n0 = tx_n;
    send_char("a"); send_char("b"); send_char("c");
    chk(tx_n == n0 && tx_valid == 1'b1, "R10", "stall holds output", tx_n - n0, 0);
    tx_ready = 1'b1;
    repeat (10) @(negedge clk);
    expect_log(base + 4, "abc", "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_garbage();
    t_lower();
    t_badcs();
    t_abort();
    t_zero();
    t_long();
    t_max();
    t_replies();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule